// File: doc/BRIEF.md
# Snooping Write-Invalidate Cache Controller

This block is the private cache controller of one processor in a small multiprocessor whose caches share a single bus. It holds eight direct-mapped lines of one 32-bit word each. Every line is Invalid, Shared or Exclusive. Exclusive means the only copy, writable and dirty. The cache is write-back, and coherence is kept by invalidation: a writer must own the block alone, and it gets that ownership by placing a write miss on the bus.

The processor side is a simple request port. A request stays asserted and stable until `cpu_rdy_o` is seen high. Loads that hit and stores that hit an Exclusive line complete in the same cycle. Every other access raises `bus_req_o` and waits for `bus_gnt_i`. It then issues an optional write-back of a dirty victim, followed by the miss command. The line is filled one cycle after the miss, from `bus_rdata_i` for a load or from the store data for a store.

Transactions that other controllers put on the bus arrive on the snoop inputs. A snoop that finds an Exclusive copy supplies the dirty word on `snp_data_o` with `snp_flush_o`. A snooped read miss then downgrades that line to Shared, and a snooped write miss invalidates it.

Top module: `snoop_cache`

## Requirements
- R1: After reset every line is Invalid: `bus_req_o` is 0, `bus_cmd_o` is 0 and `snp_flush_o` is 0, and the first access to any address goes to the bus.
- R2: A load whose index holds the same tag in Shared or Exclusive has `cpu_rdy_o` high in the request cycle, returns the line word on `cpu_rdata_o`, and causes no bus command.
- R3: A store to a line held Exclusive with the same tag completes in the request cycle without a bus command, and later loads return the new word.
- R4: A store to a line held Shared with the same tag is handled as a write miss: command 2 (write miss) is placed on the bus, and the line ends Exclusive.
- R5: A load miss issues command 1 (read miss) with the request address. The line is filled with the `bus_rdata_i` word presented in the cycle after the command and ends Shared. `cpu_rdy_o` stays low until the fill is done.
- R6: A store miss issues command 2 with the request address. The line ends Exclusive and holds the store word; the memory word is not used.
- R7: No command leaves the block unless `bus_gnt_i` is high, and `bus_req_o` stays high until the grant arrives. With G cycles of grant delay, a miss keeps `cpu_rdy_o` low for 4+G cycles, and a victim write-back adds one more.
- R8: When a miss maps to a line that is Exclusive with another tag, command 3 (write-back) is issued first, carrying the victim address {old tag, index} and its word. The miss command follows in the next cycle.
- R9: A snooped read miss (command 1) matching an Exclusive line raises `snp_flush_o` with the line word in the same cycle, and leaves the line Shared.
- R10: A snooped write miss (command 2) matching a line invalidates it. If the line was Exclusive, the word is flushed first in the same cycle.
- R11: A snoop whose tag does not match, that finds the line Invalid, or that carries command 0 or 3 neither flushes nor changes any line.
- R12: When a snooped read or write miss names the same index as the pending CPU request, `cpu_rdy_o` is low in that cycle. The snoop is applied first, and the CPU request is served afterwards against the updated line.
- R13: The decision to write back a victim is taken at grant time. If a snoop downgrades the victim while the request waits for the bus, no write-back is issued.

Address fields: index is `cpu_addr_i[2:0]`, tag is `cpu_addr_i[7:3]`; bus commands are 0 idle, 1 read miss, 2 write miss, 3 write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| cpu_req_i | input | 1 | processor request pending |
| cpu_we_i | input | 1 | request is a store |
| cpu_addr_i | input | 8 | word address of the request |
| cpu_wdata_i | input | 32 | store word |
| cpu_rdy_o | output | 1 | request completes this cycle |
| cpu_rdata_o | output | 32 | load word |
| bus_req_o | output | 1 | request for bus ownership |
| bus_gnt_i | input | 1 | bus granted to this controller |
| bus_cmd_o | output | 2 | command driven on the bus |
| bus_addr_o | output | 8 | address of the bus command |
| bus_wdata_o | output | 32 | write-back word |
| bus_rdata_i | input | 32 | memory word, valid the cycle after a miss command |
| snp_cmd_i | input | 2 | command of another controller on the bus |
| snp_addr_i | input | 8 | address of the snooped command |
| snp_flush_o | output | 1 | this cache supplies a dirty word |
| snp_data_o | output | 32 | supplied dirty word |

## Verification
A snoop and a CPU access to the same line can fall in the same cycle. The bench provokes this by presenting a store to an Exclusive line, and a load of a Shared line, in exactly the cycle a snooped miss names that index. It checks that `cpu_rdy_o` is low in that cycle and that the old word is flushed. It also checks that the retried store then goes to the bus as a write miss. A second overlap is a snoop that downgrades the victim while the request waits for a delayed grant; there the bench counts the write-back commands and requires none.

// File: rtl/snp_pkg.sv
package snp_pkg;
  typedef enum logic [1:0] {LS_INV = 2'd0, LS_SHR = 2'd1, LS_EXC = 2'd2} line_st_e;
  typedef enum logic [1:0] {BC_NONE = 2'd0, BC_RD_MISS = 2'd1, BC_WR_MISS = 2'd2, BC_WBACK = 2'd3} bus_cmd_e;
endpackage

// File: rtl/snp_line_store.sv
module snp_line_store
  import snp_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  // port a: cpu side, also fill and hit write
  input  logic [IDX_W-1:0]  a_idx_i,
  output line_st_e          a_st_o,
  output logic [TAG_W-1:0]  a_tag_o,
  output logic [DATA_W-1:0] a_data_o,
  // port b: snoop side
  input  logic [IDX_W-1:0]  b_idx_i,
  output line_st_e          b_st_o,
  output logic [TAG_W-1:0]  b_tag_o,
  output logic [DATA_W-1:0] b_data_o,
  input  logic              snp_we_i,
  input  line_st_e          snp_st_i,
  input  logic              fill_we_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  line_st_e          fill_st_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic              hit_we_i,
  input  logic [DATA_W-1:0] hit_data_i
);
  line_st_e          st_arr   [LINES];
  logic [TAG_W-1:0]  tag_arr  [LINES];
  logic [DATA_W-1:0] data_arr [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    line_st_e          st_r;
    logic [TAG_W-1:0]  tag_r;
    logic [DATA_W-1:0] data_r;
    logic              snp_sel, a_sel;
    assign snp_sel = snp_we_i && (b_idx_i == IDX_W'(g));
    assign a_sel   = (a_idx_i == IDX_W'(g));

    // snoop has priority; fill never coincides with a snoop
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_r   <= LS_INV;
        tag_r  <= '0;
        data_r <= '0;
      end else if (snp_sel) begin
        st_r <= snp_st_i;
      end else if (fill_we_i && a_sel) begin
        st_r   <= fill_st_i;
        tag_r  <= fill_tag_i;
        data_r <= fill_data_i;
      end else if (hit_we_i && a_sel) begin
        data_r <= hit_data_i;
      end
    end

    assign st_arr[g]   = st_r;
    assign tag_arr[g]  = tag_r;
    assign data_arr[g] = data_r;
  end

  assign a_st_o   = st_arr[a_idx_i];
  assign a_tag_o  = tag_arr[a_idx_i];
  assign a_data_o = data_arr[a_idx_i];
  assign b_st_o   = st_arr[b_idx_i];
  assign b_tag_o  = tag_arr[b_idx_i];
  assign b_data_o = data_arr[b_idx_i];
endmodule

// File: rtl/snp_ctrl.sv
module snp_ctrl
  import snp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_rdy_o,
  input  logic              snp_conflict_i,
  input  line_st_e          line_st_i,
  input  logic [TAG_W-1:0]  line_tag_i,
  input  logic [DATA_W-1:0] line_data_i,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output bus_cmd_e          bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              hit_we_o,
  output logic              fill_we_o,
  output line_st_e          fill_st_o,
  output logic [DATA_W-1:0] fill_data_o
);
  typedef enum logic [2:0] {S_IDLE, S_ARB, S_WB, S_MISS, S_FILL} fsm_e;
  fsm_e st_q, st_d;

  logic [TAG_W-1:0] cpu_tag;
  logic             tag_eq, hit, can_serve, victim_dirty;

  assign cpu_tag      = cpu_addr_i[ADDR_W-1:IDX_W];
  assign tag_eq       = (line_tag_i == cpu_tag);
  assign hit          = (line_st_i != LS_INV) && tag_eq;
  // a store to a Shared copy must win ownership on the bus
  assign can_serve    = hit && (!cpu_we_i || line_st_i == LS_EXC);
  assign victim_dirty = (line_st_i == LS_EXC) && !tag_eq;

  assign cpu_rdy_o = (st_q == S_IDLE) && cpu_req_i && can_serve && !snp_conflict_i;
  assign hit_we_o  = cpu_rdy_o && cpu_we_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE: if (cpu_req_i && !can_serve) st_d = S_ARB;
      // victim state is judged only once the bus is ours
      S_ARB:  if (bus_gnt_i) st_d = victim_dirty ? S_WB : S_MISS;
      S_WB:   st_d = S_MISS;
      S_MISS: st_d = S_FILL;
      S_FILL: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= S_IDLE;
    else         st_q <= st_d;
  end

  assign bus_req_o = (st_q != S_IDLE);

  always_comb begin
    bus_cmd_o   = BC_NONE;
    bus_addr_o  = cpu_addr_i;
    bus_wdata_o = '0;
    if (st_q == S_WB) begin
      bus_cmd_o   = BC_WBACK;
      bus_addr_o  = {line_tag_i, cpu_addr_i[IDX_W-1:0]};
      bus_wdata_o = line_data_i;
    end else if (st_q == S_MISS) begin
      bus_cmd_o = cpu_we_i ? BC_WR_MISS : BC_RD_MISS;
    end
  end

  assign fill_we_o   = (st_q == S_FILL);
  assign fill_st_o   = cpu_we_i ? LS_EXC : LS_SHR;
  assign fill_data_o = cpu_we_i ? cpu_wdata_i : bus_rdata_i;

  AST_CMD_NEEDS_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cmd_o != BC_NONE) |-> bus_gnt_i);  // R7
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_gnt_i) |=> bus_req_o);  // R7
  AST_NO_RDY_AT_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(bus_cmd_o) == BC_RD_MISS || $past(bus_cmd_o) == BC_WR_MISS) |-> !cpu_rdy_o);  // R5
  AST_WB_THEN_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(bus_cmd_o) == BC_WBACK) |-> (bus_cmd_o == (cpu_we_i ? BC_WR_MISS : BC_RD_MISS)));  // R8
  AST_HIT_STORE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_rdy_o && cpu_we_i) |-> (bus_cmd_o == BC_NONE));  // R3
endmodule

// File: rtl/snoop_cache.sv
module snoop_cache
  import snp_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_rdy_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic [1:0]        snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_flush_o,
  output logic [DATA_W-1:0] snp_data_o
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  cpu_idx, snp_idx;
  logic [TAG_W-1:0]  cpu_tag, snp_tag;
  line_st_e          a_st, b_st, snp_new_st, fill_st;
  logic [TAG_W-1:0]  a_tag, b_tag;
  logic [DATA_W-1:0] a_data, b_data, fill_data;
  logic              snp_miss_cmd, snp_hit, snp_we, snp_conflict;
  logic              hit_we, fill_we;
  bus_cmd_e          cmd;

  assign cpu_idx = cpu_addr_i[IDX_W-1:0];
  assign cpu_tag = cpu_addr_i[ADDR_W-1:IDX_W];
  assign snp_idx = snp_addr_i[IDX_W-1:0];
  assign snp_tag = snp_addr_i[ADDR_W-1:IDX_W];

  snp_line_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_store (
    .clk_i, .rst_ni,
    .a_idx_i(cpu_idx), .a_st_o(a_st), .a_tag_o(a_tag), .a_data_o(a_data),
    .b_idx_i(snp_idx), .b_st_o(b_st), .b_tag_o(b_tag), .b_data_o(b_data),
    .snp_we_i(snp_we), .snp_st_i(snp_new_st),
    .fill_we_i(fill_we), .fill_tag_i(cpu_tag), .fill_st_i(fill_st), .fill_data_i(fill_data),
    .hit_we_i(hit_we), .hit_data_i(cpu_wdata_i)
  );

  // snoop decode: only foreign read and write misses matter
  assign snp_miss_cmd = (snp_cmd_i == BC_RD_MISS) || (snp_cmd_i == BC_WR_MISS);
  assign snp_hit      = snp_miss_cmd && (b_st != LS_INV) && (b_tag == snp_tag);
  assign snp_flush_o  = snp_hit && (b_st == LS_EXC);
  assign snp_data_o   = snp_flush_o ? b_data : '0;
  assign snp_we       = snp_hit && (snp_cmd_i == BC_WR_MISS || b_st == LS_EXC);
  assign snp_new_st   = (snp_cmd_i == BC_WR_MISS) ? LS_INV : LS_SHR;
  assign snp_conflict = snp_miss_cmd && (snp_idx == cpu_idx);

  snp_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_ctrl (
    .clk_i, .rst_ni,
    .cpu_req_i, .cpu_we_i, .cpu_addr_i, .cpu_wdata_i, .cpu_rdy_o,
    .snp_conflict_i(snp_conflict),
    .line_st_i(a_st), .line_tag_i(a_tag), .line_data_i(a_data),
    .bus_req_o, .bus_gnt_i, .bus_cmd_o(cmd), .bus_addr_o, .bus_wdata_o, .bus_rdata_i,
    .hit_we_o(hit_we), .fill_we_o(fill_we), .fill_st_o(fill_st), .fill_data_o(fill_data)
  );

  assign bus_cmd_o   = cmd;
  assign cpu_rdata_o = a_data;

  AST_SNP_RD_DOWNGRADE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(snp_flush_o) && $past(snp_cmd_i) == BC_RD_MISS && $stable(snp_cmd_i) && $stable(snp_addr_i))
    |-> !snp_flush_o);  // R9
  AST_SNP_WR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(snp_flush_o) && $past(snp_cmd_i) == BC_WR_MISS && $stable(snp_cmd_i) && $stable(snp_addr_i))
    |-> !snp_flush_o);  // R10
  AST_SNP_STALLS_CPU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && (snp_cmd_i == 2'd1 || snp_cmd_i == 2'd2) && snp_addr_i[IDX_W-1:0] == cpu_addr_i[IDX_W-1:0])
    |-> !cpu_rdy_o);  // R12
  AST_NO_FLUSH_WHILE_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cmd_o != 2'd0) |-> !snp_flush_o);  // R7
endmodule

// File: tb/test_snoop_cache.sv
`timescale 1ns/100ps
module test_snoop_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_i = 1'b0, cpu_we_i = 1'b0;
  logic [7:0]  cpu_addr_i = '0;
  logic [31:0] cpu_wdata_i = '0;
  logic        cpu_rdy_o;
  logic [31:0] cpu_rdata_o;
  logic        bus_req_o;
  logic        bus_gnt_i = 1'b0;
  logic [1:0]  bus_cmd_o;
  logic [7:0]  bus_addr_o;
  logic [31:0] bus_wdata_o;
  logic [31:0] bus_rdata_i = '0;
  logic [1:0]  snp_cmd_i = 2'd0;
  logic [7:0]  snp_addr_i = '0;
  logic        snp_flush_o;
  logic [31:0] snp_data_o;

  always #2 clk = ~clk;

  snoop_cache i_snoop_cache (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i, .cpu_we_i, .cpu_addr_i, .cpu_wdata_i, .cpu_rdy_o, .cpu_rdata_o,
    .bus_req_o, .bus_gnt_i, .bus_cmd_o, .bus_addr_o, .bus_wdata_o, .bus_rdata_i,
    .snp_cmd_i, .snp_addr_i, .snp_flush_o, .snp_data_o
  );

  int total = 0, bad = 0;
  bit ended = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // memory, arbiter and bus log
  logic [31:0] mem  [256];
  logic [31:0] gold [256];
  int gnt_delay = 0, req_cnt = 0, cyc = 0;
  int n_wb = 0, n_rd = 0, n_wr = 0, wb_cyc = 0, miss_cyc = 0;
  logic [7:0] last_wb_addr = '0, last_miss_addr = '0, pend_addr = '0;
  bit pend = 0;

  always begin
    @(negedge clk);
    cyc++;
    if (pend) begin
      bus_rdata_i = mem[pend_addr];
      pend = 0;
    end
    if (bus_req_o) begin
      req_cnt++;
      bus_gnt_i = (req_cnt > gnt_delay);
    end else begin
      req_cnt = 0;
      bus_gnt_i = 1'b0;
    end
    #1;
    if (bus_cmd_o == 2'd3) begin
      n_wb++; wb_cyc = cyc; last_wb_addr = bus_addr_o; mem[bus_addr_o] = bus_wdata_o;
    end
    if (bus_cmd_o == 2'd1 || bus_cmd_o == 2'd2) begin
      if (bus_cmd_o == 2'd1) n_rd++; else n_wr++;
      miss_cyc = cyc; last_miss_addr = bus_addr_o; pend = 1; pend_addr = bus_addr_o;
    end
    if (snp_flush_o) mem[snp_addr_i] = snp_data_o;
  end

  // reference line model: 0 invalid, 1 shared, 2 exclusive
  logic [1:0] r_st  [8];
  logic [4:0] r_tag [8];

  task automatic access(input bit we, input logic [7:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output int waits);
    bit done = 0;
    waits = 0;
    @(negedge clk);
    cpu_req_i = 1'b1; cpu_we_i = we; cpu_addr_i = a; cpu_wdata_i = wd;
    while (!done) begin
      #1;
      if (cpu_rdy_o) begin
        done = 1; rd = cpu_rdata_o;
      end else begin
        @(negedge clk);
        waits++;
      end
    end
    @(posedge clk); #1;
    cpu_req_i = 1'b0;
  endtask

  task automatic chk_access(input bit we, input logic [7:0] a, input logic [31:0] wd, input string req);
    logic [2:0] idx = a[2:0];
    logic [4:0] tg = a[7:3];
    bit hit = (r_st[idx] != 2'd0) && (r_tag[idx] == tg);
    bit need_bus = !(hit && (!we || r_st[idx] == 2'd2));
    bit exp_wb = need_bus && r_st[idx] == 2'd2 && r_tag[idx] != tg;
    logic [7:0] wba = {r_tag[idx], idx};
    int b0 = n_wb, d0 = n_rd, w0 = n_wr, waits;
    logic [31:0] rd;
    access(we, a, wd, rd, waits);
    if (!we) chk(rd == gold[a], req, rd, gold[a]);
    chk((n_wb - b0) == int'(exp_wb), req, n_wb - b0, exp_wb);
    chk((n_rd - d0) == int'(need_bus && !we), req, n_rd - d0, need_bus && !we);
    chk((n_wr - w0) == int'(need_bus && we), req, n_wr - w0, need_bus && we);
    chk(waits == (need_bus ? 4 + gnt_delay + int'(exp_wb) : 0), "R7", waits,
        need_bus ? 4 + gnt_delay + int'(exp_wb) : 0);
    if (need_bus) chk(last_miss_addr == a, req, last_miss_addr, a);
    if (exp_wb) begin
      chk(last_wb_addr == wba, "R8", last_wb_addr, wba);
      chk(mem[wba] == gold[wba], "R8", mem[wba], gold[wba]);
      chk(miss_cyc == wb_cyc + 1, "R8", miss_cyc, wb_cyc + 1);
    end
    if (need_bus) begin
      r_st[idx] = we ? 2'd2 : 2'd1;
      r_tag[idx] = tg;
    end
    if (we) gold[a] = wd;
  endtask

  task automatic snoop(input logic [1:0] c, input logic [7:0] a, output bit fl, output logic [31:0] d);
    @(negedge clk);
    snp_cmd_i = c; snp_addr_i = a;
    #1;
    fl = snp_flush_o; d = snp_data_o;
    @(posedge clk); #1;
    snp_cmd_i = 2'd0;
  endtask

  task automatic chk_snoop(input logic [1:0] c, input logic [7:0] a, input logic [31:0] nv, input string req);
    logic [2:0] idx = a[2:0];
    bit hit = (c == 2'd1 || c == 2'd2) && r_st[idx] != 2'd0 && r_tag[idx] == a[7:3];
    bit exp_fl = hit && r_st[idx] == 2'd2;
    bit fl;
    logic [31:0] d;
    snoop(c, a, fl, d);
    chk(fl == exp_fl, req, fl, exp_fl);
    if (exp_fl) chk(d == gold[a], req, d, gold[a]);
    if (hit) r_st[idx] = (c == 2'd2) ? 2'd0 : 2'd1;
    if (c == 2'd2) begin
      @(negedge clk);
      mem[a] = nv; gold[a] = nv;  // foreign writer finishes and writes back
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!ended) begin
      ended = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 32'hC0DE0000 ^ (i * 32'h00010203);
      gold[i] = mem[i];
    end
    for (int i = 0; i < 8; i++) begin
      r_st[i] = 2'd0; r_tag[i] = '0;
    end
    repeat (3) @(negedge clk);
    #1;
    chk(bus_req_o == 1'b0, "R1", bus_req_o, 0);
    chk(bus_cmd_o == 2'd0, "R1", bus_cmd_o, 0);
    chk(snp_flush_o == 1'b0, "R1", snp_flush_o, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // sweep all lines through the local transitions
    for (int i = 0; i < 8; i++) begin
      logic [7:0] a1 = {5'd1, 3'(i)};
      logic [7:0] a2 = {5'd6, 3'(i)};
      logic [7:0] a3 = {5'd9, 3'(i)};
      chk_access(1'b0, a1, '0, "R1");                       // first touch misses
      chk_access(1'b0, a1, '0, "R2");
      chk_access(1'b1, a1, 32'h1000 + 32'(i), "R4");        // store to Shared
      chk_access(1'b1, a1, 32'h2000 + 32'(i), "R3");
      chk_access(1'b0, a1, '0, "R3");
      chk_access(1'b0, a2, '0, "R8");                       // dirty victim
      chk_access(1'b0, a2, '0, "R5");
      chk_access(1'b1, a3, 32'h3000 + 32'(i), "R6");        // clean victim
      chk_access(1'b0, a3, '0, "R6");
    end

    // snoop sweep
    for (int i = 0; i < 8; i++) begin
      logic [7:0] a3 = {5'd9, 3'(i)};
      logic [7:0] ax = {5'd4, 3'(i)};
      chk_snoop(2'd1, a3, '0, "R9");
      chk(mem[a3] == gold[a3], "R9", mem[a3], gold[a3]);
      chk_access(1'b0, a3, '0, "R9");                       // still readable
      chk_access(1'b1, a3, 32'h4000 + 32'(i), "R9");        // Shared again: write miss
      chk_snoop(2'd2, a3, 32'h5000 + 32'(i), "R10");        // Exclusive: flush then drop
      chk_access(1'b0, a3, '0, "R10");
      chk_snoop(2'd2, a3, 32'h6000 + 32'(i), "R10");        // Shared: drop silently
      chk_access(1'b0, a3, '0, "R10");
      chk_snoop(2'd1, ax, '0, "R11");
      chk_snoop(2'd2, ax, '0, "R11");
      chk_snoop(2'd3, a3, '0, "R11");
      chk_snoop(2'd0, a3, '0, "R11");
      chk_access(1'b0, a3, '0, "R11");                      // hit, untouched
    end

    // grant delay sweep with and without victim write-back
    for (int g = 0; g < 4; g++) begin
      gnt_delay = g;
      chk_access(1'b1, {5'd12, 3'(g)}, 32'h7000 + 32'(g), "R7");
      chk_access(1'b0, {5'd13, 3'(g)}, '0, "R7");
      chk_access(1'b0, {5'd14, 3'(g)}, '0, "R7");
    end
    gnt_delay = 0;

    // same-cycle store hit and foreign write miss
    begin
      logic [7:0] a = {5'd2, 3'd0};
      int w0;
      bit done = 0;
      chk_access(1'b1, a, 32'hAAAA0001, "R12");
      w0 = n_wr;
      @(negedge clk);
      cpu_req_i = 1'b1; cpu_we_i = 1'b1; cpu_addr_i = a; cpu_wdata_i = 32'hBBBB0002;
      snp_cmd_i = 2'd2; snp_addr_i = a;
      #1;
      chk(cpu_rdy_o == 1'b0, "R12", cpu_rdy_o, 0);
      chk(snp_flush_o == 1'b1, "R12", snp_flush_o, 1);
      chk(snp_data_o == 32'hAAAA0001, "R12", snp_data_o, 32'hAAAA0001);
      @(posedge clk); #1;
      snp_cmd_i = 2'd0;
      mem[a] = 32'hCCCC0003;
      while (!done) begin
        @(negedge clk); #1;
        if (cpu_rdy_o) done = 1;
      end
      @(posedge clk); #1;
      cpu_req_i = 1'b0;
      chk((n_wr - w0) == 1, "R12", n_wr - w0, 1);
      gold[a] = 32'hBBBB0002; r_st[0] = 2'd2; r_tag[0] = 5'd2;
      chk_access(1'b0, a, '0, "R12");
    end

    // same-cycle load hit and unrelated snoop on that index
    begin
      logic [7:0] a = {5'd3, 3'd1};
      int d0;
      chk_access(1'b0, a, '0, "R12");
      d0 = n_rd;
      @(negedge clk);
      cpu_req_i = 1'b1; cpu_we_i = 1'b0; cpu_addr_i = a;
      snp_cmd_i = 2'd1; snp_addr_i = {5'd30, 3'd1};
      #1;
      chk(cpu_rdy_o == 1'b0, "R12", cpu_rdy_o, 0);
      @(posedge clk); #1;
      snp_cmd_i = 2'd0;
      @(negedge clk); #1;
      chk(cpu_rdy_o == 1'b1, "R12", cpu_rdy_o, 1);
      chk(cpu_rdata_o == gold[a], "R12", cpu_rdata_o, gold[a]);
      @(posedge clk); #1;
      cpu_req_i = 1'b0;
      chk(n_rd == d0, "R12", n_rd, d0);
    end

    // victim downgraded by a snoop while waiting for the grant
    begin
      logic [7:0] av = {5'd2, 3'd5};
      logic [7:0] an = {5'd7, 3'd5};
      int b0, d0, waits;
      logic [31:0] rd;
      bit fl;
      logic [31:0] sd;
      chk_access(1'b1, av, 32'hDDDD0005, "R13");
      gnt_delay = 3;
      b0 = n_wb; d0 = n_rd;
      fork
        access(1'b0, an, '0, rd, waits);
        begin
          @(negedge clk);
          snoop(2'd1, av, fl, sd);
        end
      join
      gnt_delay = 0;
      chk(fl == 1'b1, "R13", fl, 1);
      chk(sd == 32'hDDDD0005, "R13", sd, 32'hDDDD0005);
      chk(mem[av] == 32'hDDDD0005, "R13", mem[av], 32'hDDDD0005);
      chk(n_wb == b0, "R13", n_wb - b0, 0);
      chk((n_rd - d0) == 1, "R13", n_rd - d0, 1);
      chk(rd == gold[an], "R13", rd, gold[an]);
      r_st[5] = 2'd1; r_tag[5] = 5'd7;
    end

    repeat (2) @(negedge clk);
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule